// File: doc/BRIEF.md
# Debug Scan-Chain Frame Decoder

This block sits behind a boundary-scan TAP controller and runs on the test clock. It receives the TAP's capture, shift and update strobes for the data register, two decoded instruction selects and the serial input bit. From these it rebuilds serial frames and acts on them. While the chain-select instruction is active, a frame names the internal chain that later debug frames talk to. While the debug instruction is active and the register chain is the current chain, a frame carries one register access. The block issues that access on a simple parallel register port.

Every frame ends with an 8-bit serial CRC. The block acts on a frame only if the CRC matches and the bit count is exact. A bad frame raises an error flag and changes nothing. Read data takes two frames. The read frame makes the block latch the addressed register one cycle after its request. The block then presents that value on the serial output during the next access frame, least significant bit first. The register operation finishes within two test-clock cycles after the update strobe, so the host only has to leave a short idle gap before the next frame.

Top module: `dbgf_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its reset state: `active_chain` = 4'h4 (register chain), `crc_err` = 0, `reg_req` = 0, and the held read value and `tdo` are 0.
- R2: Under `sel_chain`, a frame is 12 bits shifted least significant bit first: a 4-bit chain identifier, then the 8-bit CRC. A valid frame loads the identifier into `active_chain` at the update edge. `active_chain` changes only at an update edge under `sel_chain`, or on reset.
- R3: The CRC register starts at 8'hFF at capture. It is updated serially over every bit before the CRC field, with feedback = crc[7] XOR bit and polynomial 8'h07 (x^8+x^2+x+1). The received CRC field arrives bit 0 first and must equal the final register value.
- R4: On a CRC mismatch the block writes no register and leaves the chain unchanged. `crc_err` goes high from the update edge and stays high until the next capture strobe clears it.
- R5: Under `sel_debug` with the register chain active, a frame is 46 bits shifted least significant bit first: address[4:0], a direction bit (1 = write, 0 = read), data[31:0], then the CRC. For a valid write, the block raises `reg_req` in the cycle after the update edge, with `reg_we` = 1 and the frame's address and data.
- R6: For a valid read, the block raises `reg_req` with `reg_we` = 0, and the data bits of the frame are ignored. The block latches `reg_rdata` at the end of that request cycle. It shifts the latched value out on `tdo` during the next debug frame: bit k is on `tdo` before the k-th shift edge after capture.
- R7: When a read request sees `reg_hit` = 0 (unimplemented address), the latched value is 32'hFFFFFFFF.
- R8: The recognised chain identifiers are 4'h1 (bus), 4'h2 (processor), 4'h3 (trace) and 4'h4 (registers). A valid frame carrying any other identifier is treated as an error: `crc_err` is raised and the chain is unchanged.
- R9: A debug frame is ignored when the active chain is not the register chain: it raises no `reg_req` and no `crc_err`.
- R10: A frame whose shifted bit count differs from its exact length (12 or 46) is rejected in the same way as a CRC mismatch.
- R11: `reg_req` lasts exactly one cycle. Each accepted access frame produces one request.
- R12: An update while neither instruction select is active has no effect: no request, no error, and no change of chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset (TAP reset) |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | TAP capture strobe for the data register |
| shift_dr | input | 1 | TAP shift strobe; one bit per cycle |
| update_dr | input | 1 | TAP update strobe; ends the frame |
| sel_chain | input | 1 | Chain-select instruction is active |
| sel_debug | input | 1 | Debug instruction is active |
| tdo | output | 1 | Serial data out (held read value) |
| active_chain | output | 4 | Currently selected chain identifier |
| crc_err | output | 1 | Last frame was rejected |
| reg_req | output | 1 | One-cycle register access request |
| reg_we | output | 1 | Access direction, 1 = write |
| reg_addr | output | 5 | Register address of the access |
| reg_wdata | output | 32 | Write data of the access |
| reg_rdata | input | 32 | Read data from the register file, sampled during a read request |
| reg_hit | input | 1 | Addressed register exists |

## Verification
The embedded assertions check several rules on every cycle:
- the request is a single-cycle pulse that follows an update strobe;
- a request only ever occurs on the register chain;
- a capture clears the error flag;
- the chain selection never moves except on a chain-select update.

Other behaviour only the scenarios can show. These are the CRC arithmetic and bit ordering of frames, the one-frame delay of read data on the serial output, and the miss value of unimplemented addresses. They also cover the rejection of bad CRCs, unknown identifiers and wrong frame lengths, and the silent treatment of frames on other chains.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;
    localparam int CRC_W    = 8;
    localparam int ID_W     = 4;
    localparam int CNT_W    = 6;
    localparam int SEL_PLEN = ID_W;
    localparam int ACC_PLEN = ADDR_W + 1 + DATA_W;

    localparam logic [CRC_W-1:0]  CRC_POLY   = 8'h07;
    localparam logic [CRC_W-1:0]  CRC_INIT   = 8'hFF;
    localparam logic [DATA_W-1:0] MISS_VALUE = '1;

    localparam logic [ID_W-1:0] CH_BUS   = 4'h1;
    localparam logic [ID_W-1:0] CH_CPU   = 4'h2;
    localparam logic [ID_W-1:0] CH_TRACE = 4'h3;
    localparam logic [ID_W-1:0] CH_REG   = 4'h4;

    // Access frame payload, first shifted bit at the LSB
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } acc_frame_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic id_known(input logic [ID_W-1:0] id);
        return (id == CH_BUS) || (id == CH_CPU) || (id == CH_TRACE) || (id == CH_REG);
    endfunction

endpackage

// File: rtl/dbgf_crc_ser.sv
module dbgf_crc_ser
    import dbgf_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= CRC_INIT;
        end else if (en) begin
            crc <= crc_step(crc, din);
        end
    end

endmodule

// File: rtl/dbgf_frame_rx.sv
module dbgf_frame_rx
    import dbgf_pkg::*;
#(
    parameter int PLEN_MAX = ACC_PLEN,
    parameter int CW       = CRC_W,
    parameter int CNTW     = CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic                shift,
    input  logic                tdi,
    input  logic [CNTW-1:0]     plen,
    output logic [PLEN_MAX-1:0] payload,
    output logic [CW-1:0]       crc_rx,
    output logic [CW-1:0]       crc_calc,
    output logic [CNTW-1:0]     bit_cnt
);

    localparam logic [CNTW-1:0] CNT_MAX = '1;

    logic in_payload;
    assign in_payload = shift && (bit_cnt < plen);

    dbgf_crc_ser #(.W(CW)) u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (capture),
        .en   (in_payload),
        .din  (tdi),
        .crc  (crc_calc)
    );

    always_ff @(posedge clk) begin
        if (rst || capture) begin
            bit_cnt <= '0;
            payload <= '0;
            crc_rx  <= '0;
        end else if (shift) begin
            if (bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            for (int i = 0; i < PLEN_MAX; i++) begin
                if (in_payload && bit_cnt == CNTW'(i)) begin
                    payload[i] <= tdi;
                end
            end
            for (int j = 0; j < CW; j++) begin
                if (bit_cnt == plen + CNTW'(j)) begin
                    crc_rx[j] <= tdi;
                end
            end
        end
    end

endmodule

// File: rtl/dbgf_tdo_shift.sv
module dbgf_tdo_shift
    import dbgf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          shift,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    output logic          tdo
);

    logic [DW-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture) begin
            sr <= load_en ? load_val : '0;
        end else if (shift) begin
            sr <= {1'b0, sr[DW-1:1]};
        end
    end

    assign tdo = sr[0];

    // R6
    tdo_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (!capture && !shift) |=> $stable(tdo));

endmodule

// File: rtl/dbgf_decoder.sv
module dbgf_decoder
    import dbgf_pkg::*;
(
    input  logic              tck,
    input  logic              rst,
    input  logic              tdi,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              sel_chain,
    input  logic              sel_debug,
    output logic              tdo,
    output logic [ID_W-1:0]   active_chain,
    output logic              crc_err,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_hit
);

    logic [CNT_W-1:0]    plen;
    logic [ACC_PLEN-1:0] payload;
    logic [CRC_W-1:0]    crc_rx;
    logic [CRC_W-1:0]    crc_calc;
    logic [CNT_W-1:0]    bit_cnt;
    logic [DATA_W-1:0]   rd_hold;
    acc_frame_t          acc;
    logic                frame_good;
    logic                reg_chain;

    assign plen       = sel_chain ? CNT_W'(SEL_PLEN) : CNT_W'(ACC_PLEN);
    assign acc        = acc_frame_t'(payload);
    assign reg_chain  = (active_chain == CH_REG);
    assign frame_good = (crc_rx == crc_calc) && (bit_cnt == plen + CNT_W'(CRC_W));

    dbgf_frame_rx #(.PLEN_MAX(ACC_PLEN), .CW(CRC_W), .CNTW(CNT_W)) u_rx (
        .clk      (tck),
        .rst      (rst),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .tdi      (tdi),
        .plen     (plen),
        .payload  (payload),
        .crc_rx   (crc_rx),
        .crc_calc (crc_calc),
        .bit_cnt  (bit_cnt)
    );

    dbgf_tdo_shift #(.DW(DATA_W)) u_tdo (
        .clk      (tck),
        .rst      (rst),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .load_en  (sel_debug && reg_chain),
        .load_val (rd_hold),
        .tdo      (tdo)
    );

    always_ff @(posedge tck) begin
        if (rst) begin
            active_chain <= CH_REG;
            crc_err      <= 1'b0;
            reg_req      <= 1'b0;
            reg_we       <= 1'b0;
            reg_addr     <= '0;
            reg_wdata    <= '0;
            rd_hold      <= '0;
        end else begin
            reg_req <= 1'b0;
            if (capture_dr) begin
                crc_err <= 1'b0;
            end
            if (reg_req && !reg_we) begin
                rd_hold <= reg_hit ? reg_rdata : MISS_VALUE;
            end
            if (update_dr) begin
                if (sel_chain) begin
                    if (frame_good && id_known(payload[ID_W-1:0])) begin
                        active_chain <= payload[ID_W-1:0];
                    end else begin
                        crc_err <= 1'b1;
                    end
                end else if (sel_debug && reg_chain) begin
                    if (frame_good) begin
                        reg_req   <= 1'b1;
                        reg_we    <= acc.wr;
                        reg_addr  <= acc.addr;
                        reg_wdata <= acc.data;
                    end else begin
                        crc_err <= 1'b1;
                    end
                end
            end
        end
    end

    // R11
    req_pulse_chk: assert property (@(posedge tck) disable iff (rst)
        reg_req |=> !reg_req);

    // R5
    req_after_upd_chk: assert property (@(posedge tck) disable iff (rst)
        reg_req |-> $past(update_dr));

    // R9
    req_chain_chk: assert property (@(posedge tck) disable iff (rst)
        reg_req |-> (active_chain == CH_REG));

    // R4
    err_clear_chk: assert property (@(posedge tck) disable iff (rst)
        capture_dr |=> !crc_err);

    // R2
    chain_move_chk: assert property (@(posedge tck) disable iff (rst)
        (!$past(rst) && active_chain != $past(active_chain)) |-> $past(update_dr && sel_chain));

endmodule

// File: tb/tb_dbgf_decoder.sv
module tb_dbgf_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NWR = 6;
    localparam logic [37:0] WR_TAB [NWR] = '{
        {32'hBEEF0001, 1'b1, 5'd0},
        {32'h12345678, 1'b1, 5'd1},
        {32'hA5A5A5A5, 1'b1, 5'd2},
        {32'h00000000, 1'b1, 5'd3},
        {32'hFFFFFFFF, 1'b1, 5'd4},
        {32'h80000001, 1'b1, 5'd5}
    };

    logic tck = 1'b0;
    logic rst, tdi, capture_dr, shift_dr, update_dr, sel_chain, sel_debug;
    logic tdo, crc_err, reg_req, reg_we, reg_hit;
    logic [3:0]  active_chain;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [31:0] rf [8];

    int checks = 0;
    int errs = 0;
    int cyc = 0;

    dbgf_decoder dut (
        .tck(tck), .rst(rst), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .sel_chain(sel_chain),
        .sel_debug(sel_debug), .tdo(tdo), .active_chain(active_chain),
        .crc_err(crc_err), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_hit(reg_hit)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    assign reg_hit   = (reg_addr < 5'd8);
    assign reg_rdata = rf[reg_addr[2:0]];

    always @(posedge tck) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) rf[i] <= 32'h0;
        end else if (reg_req && reg_we && reg_addr < 5'd8) begin
            rf[reg_addr[2:0]] <= reg_wdata;
        end
    end

    always @(posedge tck) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errs = errs + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errs = errs + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_of(input logic [63:0] b, input int n, input logic [7:0] init);
        logic [7:0] c;
        logic fb;
        c = init;
        for (int i = 0; i < n; i++) begin
            fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [63:0] acc_frame(input logic wr, input logic [4:0] a,
                                              input logic [31:0] d, input logic [7:0] cx);
        logic [63:0] p;
        p = {26'h0, d, wr, a};
        return p | ({56'h0, crc_of(p, 38, 8'hFF) ^ cx} << 38);
    endfunction

    function automatic logic [63:0] sel_frame(input logic [3:0] id, input logic [7:0] cx);
        logic [63:0] p;
        p = {60'h0, id};
        return p | ({56'h0, crc_of(p, 4, 8'hFF) ^ cx} << 4);
    endfunction

    logic        f_req, f_we, f_err, f_errcap, f_req2;
    logic [4:0]  f_addr;
    logic [31:0] f_wdata;
    logic [63:0] f_tdo;

    task automatic run_frame(input logic [63:0] bits, input int n);
        @(negedge tck) capture_dr = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            capture_dr = 1'b0;
            shift_dr = 1'b1;
            f_tdo[i] = tdo;
            tdi = bits[i];
        end
        @(negedge tck);
        shift_dr = 1'b0;
        tdi = 1'b0;
        f_errcap = crc_err;
        @(negedge tck) update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0;
        f_req = reg_req;
        f_we = reg_we;
        f_addr = reg_addr;
        f_wdata = reg_wdata;
        f_err = crc_err;
        @(negedge tck) f_req2 = reg_req;
        @(negedge tck);
    endtask

    task automatic do_select(input logic [3:0] id, input logic [7:0] cx);
        sel_chain = 1'b1;
        sel_debug = 1'b0;
        run_frame(sel_frame(id, cx), 12);
        sel_chain = 1'b0;
        sel_debug = 1'b1;
    endtask

    initial begin
        rst = 1'b1; tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
        sel_chain = 0; sel_debug = 1'b1; f_tdo = '0;
        repeat (3) @(negedge tck);
        // R1 reset state
        check(active_chain == 4'h4, "R1 chain", 64'(active_chain), 64'h4);
        check(crc_err == 1'b0, "R1 err", 64'(crc_err), 64'h0);
        check(reg_req == 1'b0, "R1 req", 64'(reg_req), 64'h0);
        check(tdo == 1'b0, "R1 tdo", 64'(tdo), 64'h0);
        rst = 1'b0;
        @(negedge tck);

        // R5 writes from the vector table, R11 single pulse
        for (int k = 0; k < NWR; k++) begin
            run_frame(acc_frame(1'b1, WR_TAB[k][4:0], WR_TAB[k][37:6], 8'h00), 46);
            check(f_req && f_we && f_addr == WR_TAB[k][4:0] && f_wdata == WR_TAB[k][37:6] && !f_err,
                  "R5 write request", {26'h0, f_wdata, f_we, f_addr}, {26'h0, WR_TAB[k]});
            check(!f_req2, "R11 pulse length", 64'(f_req2), 64'h0);
        end

        // R6 reads: data appears on the following frame, R3 CRC accepted
        run_frame(acc_frame(1'b0, 5'd0, 32'hDEADDEAD, 8'h00), 46);
        check(f_req && !f_we && f_addr == 5'd0, "R6 read request", {f_req, f_we}, 64'h2);
        for (int k = 0; k < NWR; k++) begin
            run_frame(acc_frame(1'b0, 5'(k + 1), 32'h0, 8'h00), 46);
            check(f_tdo[31:0] == WR_TAB[k][37:6], "R6 read data on tdo",
                  64'(f_tdo[31:0]), 64'(WR_TAB[k][37:6]));
        end

        // R2 select bus chain, R9 debug frame on it ignored
        do_select(4'h1, 8'h00);
        check(active_chain == 4'h1 && !f_err, "R2 chain select", 64'(active_chain), 64'h1);
        run_frame(acc_frame(1'b1, 5'd0, 32'h11111111, 8'h00), 46);
        check(!f_req && !f_err, "R9 ignored off register chain", {f_req, f_err}, 64'h0);
        do_select(4'h4, 8'h00);
        check(active_chain == 4'h4, "R2 back to register chain", 64'(active_chain), 64'h4);

        // R4 bad CRC on a chain select
        do_select(4'h3, 8'h01);
        check(f_err && active_chain == 4'h4, "R4 bad crc select", {f_err, active_chain}, 64'h14);
        repeat (3) @(negedge tck);
        check(crc_err == 1'b1, "R4 error held", 64'(crc_err), 64'h1);
        // R8 unknown id with good CRC; R4 error cleared at capture
        do_select(4'h9, 8'h00);
        check(!f_errcap, "R4 error cleared by capture", 64'(f_errcap), 64'h0);
        check(f_err && active_chain == 4'h4, "R8 unknown id", {f_err, active_chain}, 64'h14);
        do_select(4'h3, 8'h00);
        check(!f_err && active_chain == 4'h3, "R8 trace id", 64'(active_chain), 64'h3);
        do_select(4'h4, 8'h00);

        // R4 bad CRC on a write: register kept
        run_frame(acc_frame(1'b1, 5'd2, 32'h0BADF00D, 8'h80), 46);
        check(!f_req && f_err, "R4 bad crc write", {f_req, f_err}, 64'h1);
        // R3 CRC seeded with 0x00 instead of 0xFF is rejected
        begin
            logic [63:0] p;
            p = {26'h0, 32'h0BADF00D, 1'b1, 5'd2};
            p = p | ({56'h0, crc_of(p, 38, 8'h00)} << 38);
            run_frame(p, 46);
            check(!f_req && f_err, "R3 wrong crc seed", {f_req, f_err}, 64'h1);
        end
        run_frame(acc_frame(1'b0, 5'd2, 32'h0, 8'h00), 46);
        run_frame(acc_frame(1'b0, 5'd0, 32'h0, 8'h00), 46);
        check(f_tdo[31:0] == 32'hA5A5A5A5, "R4 register unchanged", 64'(f_tdo[31:0]), 64'hA5A5A5A5);

        // R10 wrong frame lengths
        run_frame(acc_frame(1'b1, 5'd1, 32'h77777777, 8'h00), 47);
        check(!f_req && f_err, "R10 long frame", {f_req, f_err}, 64'h1);
        run_frame(acc_frame(1'b1, 5'd1, 32'h77777777, 8'h00), 45);
        check(!f_req && f_err, "R10 short frame", {f_req, f_err}, 64'h1);

        // R7 unimplemented address
        run_frame(acc_frame(1'b0, 5'h1f, 32'h0, 8'h00), 46);
        run_frame(acc_frame(1'b0, 5'd0, 32'h0, 8'h00), 46);
        check(f_tdo[31:0] == 32'hFFFFFFFF, "R7 miss value", 64'(f_tdo[31:0]), 64'hFFFFFFFF);

        // R12 no instruction selected
        sel_debug = 1'b0;
        run_frame(acc_frame(1'b1, 5'd3, 32'h55555555, 8'h00), 46);
        check(!f_req && !f_err && active_chain == 4'h4, "R12 no instruction",
              {f_req, f_err, active_chain}, 64'h4);
        sel_debug = 1'b1;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule